// File: doc/BRIEF.md
# SD Card Clock Divider and Gate

This block makes the clock that goes out to an SD card. All logic runs on one system clock. Three base clocks are presented as tick inputs: one from the bus clock, one from a PLL and one from an external source. Each tick marks one half-period of that base clock. A two-bit source field picks which tick stream drives the block. A 16-bit clock-control word carries four things:

- an internal-clock enable;
- a read-only stable flag;
- an SD clock enable;
- an 8-bit frequency select.

The frequency select holds half the division ratio. Zero passes the base clock through undivided.

Software sets the internal enable and then waits for the stable flag. It then sets the SD clock enable. To change the divisor it first writes zero to the control word, then writes the new value. The block drives three outputs: the card clock pin level, a one-cycle strobe at each rising edge of that pin, and the stable flag.

Top module: `sd_clk_gen`

## Requirements
- R1: After reset the control readback is 0x0000, and the pin, the strobe and the stable flag are all low.
- R2: The control word is laid out as follows: bits [15:8] frequency select, bit 2 SD clock enable, bit 1 stable (read-only, written value ignored), bit 0 internal enable. Bits [7:3] read back as written.
- R3: The stable flag rises on the 16th selected tick (8 base-clock periods) after internal enable is written to 1. It is low before then.
- R4: The stable flag drops in the same cycle that a write clearing internal enable takes effect. The pin goes low in that same cycle.
- R5: The pin is low unless internal enable, SD clock enable and stable are all 1. An SD clock enable set before stable has no effect until stable rises.
- R6: While running, each pin half-period lasts h selected ticks, where h = 1 for frequency select 0 and h = 2·F otherwise. The full period is therefore 2·h ticks, which is the base clock divided by 2·F.
- R7: The strobe is high for exactly one system cycle, in the cycle the pin rises. It is never high at any other time.
- R8: On start-up the pin first stays low for a full h ticks, then stays high for a full h ticks. There is no runt pulse.
- R9: A frequency select written while running takes effect only at the next rising edge of the pin. The period in progress keeps the old length.
- R10: Source field values 00 and 01 select the bus tick, 10 selects the PLL tick and 11 selects the external tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ccr_we | input | 1 | Clock-control write strobe |
| ccr_wdata | input | 16 | Clock-control write data |
| src_we | input | 1 | Source-select write strobe |
| src_wdata | input | 2 | Source select (00/01 bus, 10 PLL, 11 external) |
| bus_tick | input | 1 | Bus base clock half-period tick |
| pll_tick | input | 1 | PLL base clock half-period tick |
| ext_tick | input | 1 | External base clock half-period tick |
| ccr_rdata | output | 16 | Clock-control readback with live stable bit |
| sd_pin | output | 1 | SD clock pin level |
| sd_stb | output | 1 | One-cycle strobe at each pin rising edge |
| clk_stable | output | 1 | Internal clock stable flag |

## Verification
The bench counts the stable delay cycle by cycle. A counter that is off by one, or that counts system cycles instead of ticks, shifts the rise. It enables the SD clock before stable and watches for an early pin edge. That edge would show up if the gate ignored the stable flag. It also measures the first low and high halves after start-up, where a stale count would produce a short first pulse. It writes a new divisor just after a rising edge and expects the old period once more. A design that reloads on every toggle would stretch or shorten that period. Finally it measures periods on each source selection, including the undivided setting and the largest ratio. A wrong tick mux, or a divisor that is not doubled, shows up there as a wrong period.

// File: rtl/sd_clk_gen.sv
module sd_clk_gen #(
  parameter int FSEL_W       = 8,
  parameter int STABLE_TICKS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ccr_we,
  input  logic [FSEL_W+7:0]   ccr_wdata,
  input  logic                src_we,
  input  logic [1:0]          src_wdata,
  input  logic                bus_tick,
  input  logic                pll_tick,
  input  logic                ext_tick,
  output logic [FSEL_W+7:0]   ccr_rdata,
  output logic                sd_pin,
  output logic                sd_stb,
  output logic                clk_stable
);
  localparam int CCR_W = FSEL_W + 8;
  localparam int HW    = FSEL_W + 1;
  localparam int SCW   = $clog2(STABLE_TICKS + 1);

  logic [CCR_W-1:2] ccr_hi;
  logic             ien_q;
  logic [1:0]       src_q;
  logic             stab_q;
  logic [SCW-1:0]   scnt;
  logic [HW-1:0]    hlen, hcnt, cur_h;
  logic             pin_q, stb_q, tick, run, wrap;
  logic [FSEL_W-1:0] fsel;

  assign fsel       = ccr_hi[CCR_W-1:8];
  assign clk_stable = stab_q & ien_q;
  assign run        = clk_stable & ccr_hi[2];
  assign cur_h      = (fsel == '0) ? HW'(1) : {fsel, 1'b0};
  assign wrap       = (hcnt == hlen - HW'(1));
  assign ccr_rdata  = {ccr_hi, clk_stable, ien_q};
  assign sd_pin     = pin_q & run;
  assign sd_stb     = stb_q & run;

  always_comb begin
    case (src_q)
      2'b10:   tick = pll_tick;
      2'b11:   tick = ext_tick;
      default: tick = bus_tick;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccr_hi <= '0;
      ien_q  <= 1'b0;
      src_q  <= 2'b00;
    end else begin
      if (ccr_we) begin
        ccr_hi <= ccr_wdata[CCR_W-1:2];
        ien_q  <= ccr_wdata[0];
      end
      if (src_we) src_q <= src_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !ien_q) begin
      scnt   <= '0;
      stab_q <= 1'b0;
    end else if (tick && !stab_q) begin
      scnt <= scnt + SCW'(1);
      if (scnt == SCW'(STABLE_TICKS - 1)) stab_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      stb_q <= 1'b0;
      hcnt  <= '0;
      hlen  <= HW'(1);
    end else if (!run) begin
      pin_q <= 1'b0;
      stb_q <= 1'b0;
      hcnt  <= '0;
      hlen  <= cur_h;
    end else if (tick) begin
      stb_q <= wrap & ~pin_q;
      if (wrap) begin
        hcnt  <= '0;
        pin_q <= ~pin_q;
        if (!pin_q) hlen <= cur_h;
      end else begin
        hcnt <= hcnt + HW'(1);
      end
    end else begin
      stb_q <= 1'b0;
    end
  end
endmodule

module sd_clk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic ien,
  input logic sden,
  input logic stable,
  input logic pin,
  input logic stb
);
  a_r5_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !(ien && sden && stable) |-> !pin);
  a_r3_stable_needs_ien: assert property (@(posedge clk) disable iff (!rst_n)
    stable |-> ien);
  a_r4_stable_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stable) |-> !ien);
  a_r7_stb_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> $rose(pin));
  a_r7_rise_has_stb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin) |-> stb);
endmodule

bind sd_clk_gen sd_clk_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ien(ccr_rdata[0]), .sden(ccr_rdata[2]),
  .stable(clk_stable), .pin(sd_pin), .stb(sd_stb)
);

// File: tb/sd_clk_gen_bench.sv
module sd_clk_gen_bench;
  logic clk = 0, rst_n = 0;
  logic ccr_we = 0, src_we = 0;
  logic [15:0] ccr_wdata = 0;
  logic [1:0] src_wdata = 0;
  logic bus_tick = 1, pll_tick = 0, ext_tick = 0;
  logic [15:0] ccr_rdata;
  logic sd_pin, sd_stb, clk_stable;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  sd_clk_gen u_sd_clk_gen (
    .clk(clk), .rst_n(rst_n), .ccr_we(ccr_we), .ccr_wdata(ccr_wdata),
    .src_we(src_we), .src_wdata(src_wdata), .bus_tick(bus_tick),
    .pll_tick(pll_tick), .ext_tick(ext_tick), .ccr_rdata(ccr_rdata),
    .sd_pin(sd_pin), .sd_stb(sd_stb), .clk_stable(clk_stable)
  );

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc++;
      pll_tick = (tc % 2) == 0;
      ext_tick = (tc % 4) == 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ccr(input logic [15:0] d);
    ccr_wdata = d; ccr_we = 1;
    @(negedge clk);
    ccr_we = 0;
  endtask

  task automatic wr_src(input logic [1:0] d);
    src_wdata = d; src_we = 1;
    @(negedge clk);
    src_we = 0;
  endtask

  task automatic wait_stb();
    int n = 0;
    while (!sd_stb && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic measure(output int p);
    wait_stb();
    p = 0;
    do begin @(negedge clk); p++; end while (!sd_stb && p < 3000);
  endtask

  task automatic t_reset();
    chk("R1 rdata", ccr_rdata, 0);
    chk("R1 pin", sd_pin, 0);
    chk("R1 stb", sd_stb, 0);
    chk("R1 stable", clk_stable, 0);
  endtask

  task automatic t_regs();
    wr_ccr(16'hA5FA);
    chk("R2 readback, bit1 ignored", ccr_rdata, 16'hA5F8);
    wr_ccr(16'h0000);
    chk("R2 cleared", ccr_rdata, 0);
  endtask

  task automatic t_stable();
    int err = 0;
    wr_ccr(16'h0001);
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (clk_stable != (k >= 16)) err++;
    end
    chk("R3 stable timing mismatches", err, 0);
    chk("R3 rdata bit1", ccr_rdata[1], 1);
    wr_ccr(16'h0000);
    chk("R4 stable drops", clk_stable, 0);
  endtask

  task automatic t_gate();
    int first = 0, high = 0, err = 0;
    wr_ccr(16'h0205);
    for (int k = 1; k <= 30 && first == 0; k++) begin
      @(negedge clk);
      if (sd_pin && !clk_stable) err++;
      if (sd_pin) first = k;
    end
    chk("R5 pin high before stable", err, 0);
    chk("R8 first rise cycle", first, 20);
    while (sd_pin && high < 50) begin high++; @(negedge clk); end
    chk("R8 first high width", high, 4);
    wr_ccr(16'h0201);
    err = 0;
    for (int k = 0; k < 12; k++) begin
      if (sd_pin) err++;
      @(negedge clk);
    end
    chk("R5 pin low with sd enable off", err, 0);
    chk("R5 stable kept", clk_stable, 1);
  endtask

  task automatic t_ratio();
    int p;
    int fs[4] = '{0, 1, 3, 128};
    int ex[4] = '{2, 4, 12, 512};
    for (int i = 0; i < 4; i++) begin
      wr_ccr(16'((fs[i] << 8) | 5));
      measure(p);
      measure(p);
      chk($sformatf("R6 period fsel=%0d", fs[i]), p, ex[i]);
    end
    wr_ccr(16'h0105);
    wait_stb();
    wait_stb();
    chk("R7 pin high at strobe", sd_pin, 1);
    @(negedge clk);
    chk("R7 strobe one cycle", sd_stb, 0);
    chk("R7 pin still high", sd_pin, 1);
  endtask

  task automatic t_change();
    int p;
    wr_ccr(16'h0205);
    measure(p);
    measure(p);
    wr_ccr(16'h0105);
    p = 1;
    while (!sd_stb && p < 100) begin @(negedge clk); p++; end
    chk("R9 period in progress keeps old", p, 8);
    measure(p);
    chk("R9 next period new", p, 4);
  endtask

  task automatic t_src();
    int p;
    logic [1:0] s[4] = '{2'b10, 2'b11, 2'b01, 2'b00};
    int ex[4] = '{8, 16, 4, 4};
    wr_ccr(16'h0105);
    for (int i = 0; i < 4; i++) begin
      wr_src(s[i]);
      measure(p);
      measure(p);
      measure(p);
      chk($sformatf("R10 period src=%0d", s[i]), p, ex[i]);
    end
  endtask

  task automatic t_off();
    wr_ccr(16'h0204);
    chk("R4 stable low", clk_stable, 0);
    chk("R4 pin low", sd_pin, 0);
    chk("R4 rdata", ccr_rdata, 16'h0204);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_stable();
    t_gate();
    t_ratio();
    t_change();
    t_src();
    t_off();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule